// File: doc/BRIEF.md
# Per-Sector Write Protection Controller

This block keeps a protection state for every erase sector of a non-volatile word-addressed array. It also decides, in the same cycle, whether a program or erase request aimed at a word address may go ahead. The array has eight small sectors of 4K words and thirty-one large sectors of 32K words, 2^20 words in all. A static configuration input chooses whether the small sectors cover the lowest or the highest 32K words. Sectors are numbered in ascending address order. The controller turns both command and request addresses into sector numbers.

Each sector is in one of three states: open, locked or frozen (locked down). Lock, unlock and freeze commands change a single sector's state at the clock edge that accepts them. Every sector starts in the locked state after reset. A programming-voltage-low indication overrides every sector and denies all requests. A write-protect hold input keeps frozen sectors frozen. When the hold is released, an unlock command reopens a frozen sector. A denied request gives a one-cycle error pulse that carries the sector number. Any sector's state can be read through a sector-select port.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector reads status 2'b01 (locked), and a request to any address is denied.
- R2: With `small_at_top`=0, addresses below 0x08000 fall in sectors 0..7, one per 0x1000 words. An address A at or above 0x08000 falls in sector 7 + A[19:15].
- R3: With `small_at_top`=1, addresses below 0xF8000 fall in sector A[19:15] (0..30). Addresses at or above 0xF8000 fall in sector 31 + A[14:12].
- R4: A command with `cmd_op`=2'b01 (lock) moves an open sector to status 2'b01. The new status is visible in the cycle after the accepting edge.
- R5: A command with `cmd_op`=2'b10 (unlock) moves a locked sector to status 2'b00 (open) at the accepting edge.
- R6: A command with `cmd_op`=2'b11 (freeze) moves a sector in any state to status 2'b11. A lock command sent to a frozen sector leaves it at 2'b11.
- R7: While `wp_hold`=1, an unlock command sent to a frozen sector leaves it at 2'b11. While `wp_hold`=0, the same command moves it to 2'b00.
- R8: `req_permit` is 1 in the same cycle as `req_valid`, with no register in between, only when the addressed sector is open and `vpp_low`=0.
- R9: While `vpp_low`=1, every request is denied, even one to an open sector.
- R10: A request that is denied in one cycle raises `err_valid` for exactly the next cycle, with `err_sector` set to the sector number. A request that is permitted raises no error.
- R11: `stat_lock` shows the state of sector `stat_sel` combinationally: bit 0 is locked and bit 1 is frozen. A `stat_sel` of 39 or more reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| small_at_top | input | 1 | 1: small sectors occupy the top 32K words |
| wp_hold | input | 1 | Keeps frozen sectors frozen while high |
| vpp_low | input | 1 | Programming voltage too low: deny all requests |
| cmd_valid | input | 1 | Protection command strobe |
| cmd_op | input | 2 | 01 lock, 10 unlock, 11 freeze, 00 no-op |
| cmd_addr | input | 20 | Word address selecting the command's sector |
| req_valid | input | 1 | Program/erase request strobe |
| req_addr | input | 20 | Word address of the request |
| req_permit | output | 1 | Request may proceed (combinational) |
| err_valid | output | 1 | One-cycle pulse after a denied request |
| err_sector | output | 6 | Sector number of the denied request |
| stat_sel | input | 6 | Sector whose state is read |
| stat_lock | output | 2 | {frozen, locked} of the selected sector |

## Verification
There are three timings to check. `req_permit` and `stat_lock` are combinational, so the bench samples them 1 ns after driving their inputs on a falling edge. A command counts at the rising edge after it is driven, so its effect is read on the next falling edge. `err_valid` and `err_sector` are registered and come one edge after the denied request: the bench holds the request for exactly one rising edge, checks the pulse on the following falling edge, and checks that the pulse has ended one cycle later.

// File: rtl/sg_pkg.sv
package sg_pkg;
   typedef enum logic [1:0] {
      LS_OPEN   = 2'b00,
      LS_LOCKED = 2'b01,
      LS_FROZEN = 2'b11
   } lock_e;

   typedef enum logic [1:0] {
      OP_NONE   = 2'b00,
      OP_LOCK   = 2'b01,
      OP_UNLOCK = 2'b10,
      OP_FREEZE = 2'b11
   } op_e;
endpackage

// File: rtl/sg_sector_decode.sv
module sg_sector_decode #(
   parameter int ADDR_W     = 20,
   parameter int SMALL_LOG2 = 12,
   parameter int LARGE_LOG2 = 15,
   parameter int N_SMALL    = 8,
   parameter int N_LARGE    = 31,
   parameter int IDX_W      = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              small_top,
   output logic [IDX_W-1:0]  idx
);
   localparam int HI_W = ADDR_W - LARGE_LOG2;
   localparam int LO_W = LARGE_LOG2 - SMALL_LOG2;

   logic [HI_W-1:0] hi;
   logic [LO_W-1:0] lo;

   assign hi = addr[ADDR_W-1:LARGE_LOG2];
   assign lo = addr[LARGE_LOG2-1:SMALL_LOG2];

   always_comb begin
      if (small_top) begin
         if (hi == HI_W'(N_LARGE)) idx = IDX_W'(N_LARGE) + IDX_W'(lo);
         else                      idx = IDX_W'(hi);
      end else begin
         if (hi == '0) idx = IDX_W'(lo);
         else          idx = IDX_W'(N_SMALL - 1) + IDX_W'(hi);
      end
   end
endmodule

// File: rtl/sg_lock_cell.sv
module sg_lock_cell
   import sg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  hit,
   input  op_e   op,
   input  logic  wp_hold,
   output lock_e st
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= LS_LOCKED;
      end else if (hit) begin
         unique case (op)
            OP_LOCK:   if (st == LS_OPEN) st <= LS_LOCKED;
            OP_UNLOCK: if (st == LS_LOCKED || !wp_hold) st <= LS_OPEN;
            OP_FREEZE: st <= LS_FROZEN;
            default:   st <= st;
         endcase
      end
   end
endmodule

// File: rtl/sector_guard.sv
module sector_guard
   import sg_pkg::*;
#(
   parameter int ADDR_W     = 20,
   parameter int SMALL_LOG2 = 12,
   parameter int LARGE_LOG2 = 15,
   parameter int N_SMALL    = 8,
   parameter int N_LARGE    = 31,
   parameter int IDX_W      = $clog2(N_SMALL + N_LARGE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              small_at_top,
   input  logic              wp_hold,
   input  logic              vpp_low,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_permit,
   output logic              err_valid,
   output logic [IDX_W-1:0]  err_sector,
   input  logic [IDX_W-1:0]  stat_sel,
   output logic [1:0]        stat_lock
);
   localparam int N_SEC = N_SMALL + N_LARGE;
   localparam int HI_W  = ADDR_W - LARGE_LOG2;
   localparam int LO_W  = LARGE_LOG2 - SMALL_LOG2;

   if ((1 << LO_W) != N_SMALL) begin : g_bad_small
      $error("small sectors must fill exactly one large sector slot");
   end
   if ((1 << HI_W) != N_LARGE + 1) begin : g_bad_large
      $error("large sectors plus the small group must fill the address space");
   end
   if ((1 << IDX_W) < N_SEC) begin : g_bad_idx
      $error("IDX_W too narrow for the sector count");
   end

   logic [IDX_W-1:0]   cmd_idx;
   logic [IDX_W-1:0]   req_idx;
   lock_e              st_vec [N_SEC];
   logic [2*N_SEC-1:0] st_flat;

   sg_sector_decode #(
      .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2),
      .N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .IDX_W(IDX_W)
   ) u_dec_cmd (
      .addr(cmd_addr), .small_top(small_at_top), .idx(cmd_idx)
   );

   sg_sector_decode #(
      .ADDR_W(ADDR_W), .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2),
      .N_SMALL(N_SMALL), .N_LARGE(N_LARGE), .IDX_W(IDX_W)
   ) u_dec_req (
      .addr(req_addr), .small_top(small_at_top), .idx(req_idx)
   );

   for (genvar i = 0; i < N_SEC; i++) begin : g_cell
      sg_lock_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .hit     (cmd_valid && (cmd_idx == IDX_W'(i))),
         .op      (op_e'(cmd_op)),
         .wp_hold (wp_hold),
         .st      (st_vec[i])
      );
      assign st_flat[2*i +: 2] = st_vec[i];
   end

   logic req_open;
   assign req_open   = (st_flat[{req_idx, 1'b0} +: 2] == LS_OPEN);
   assign req_permit = req_valid && !vpp_low && req_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_valid  <= 1'b0;
         err_sector <= '0;
      end else begin
         err_valid  <= req_valid && !req_permit;
         err_sector <= req_valid ? req_idx : err_sector;
      end
   end

   always_comb begin
      if (stat_sel < IDX_W'(N_SEC)) stat_lock = st_flat[{stat_sel, 1'b0} +: 2];
      else                          stat_lock = 2'b00;
   end
endmodule

// File: rtl/sg_checker.sv
module sg_checker #(
   parameter int N_SEC = 39,
   parameter int IDX_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vpp_low,
   input logic              wp_hold,
   input logic              req_valid,
   input logic              req_permit,
   input logic [IDX_W-1:0]  req_idx,
   input logic              err_valid,
   input logic [IDX_W-1:0]  err_sector,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [IDX_W-1:0]  cmd_idx,
   input logic [2*N_SEC-1:0] st_flat
);
   AST_VPP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && vpp_low) |-> !req_permit); // R9

   AST_PERMIT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      req_permit |-> (st_flat[{req_idx, 1'b0} +: 2] == 2'b00)); // R8

   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_permit) |=> (err_valid && err_sector == $past(req_idx))); // R10

   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> $past(req_valid && !req_permit)); // R10

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b10 && wp_hold && st_flat[{cmd_idx, 1'b0} +: 2] == 2'b11)
      |=> (st_flat[{$past(cmd_idx), 1'b0} +: 2] == 2'b11)); // R7

   AST_LOCK_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'b01) |=> (st_flat[{$past(cmd_idx), 1'b0} +: 2] != 2'b00)); // R4
endmodule

bind sector_guard sg_checker #(.N_SEC(N_SEC), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .vpp_low(vpp_low), .wp_hold(wp_hold),
   .req_valid(req_valid), .req_permit(req_permit), .req_idx(req_idx),
   .err_valid(err_valid), .err_sector(err_sector),
   .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
   .st_flat(st_flat)
);

// File: tb/sector_guard_bench.sv
module sector_guard_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        small_at_top = 1'b0;
   logic        wp_hold = 1'b1;
   logic        vpp_low = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [19:0] cmd_addr = '0;
   logic        req_valid = 1'b0;
   logic [19:0] req_addr = '0;
   logic        req_permit;
   logic        err_valid;
   logic [5:0]  err_sector;
   logic [5:0]  stat_sel = '0;
   logic [1:0]  stat_lock;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   sector_guard u_sector_guard (
      .clk(clk), .rst_n(rst_n), .small_at_top(small_at_top), .wp_hold(wp_hold),
      .vpp_low(vpp_low), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .req_valid(req_valid), .req_addr(req_addr), .req_permit(req_permit),
      .err_valid(err_valid), .err_sector(err_sector),
      .stat_sel(stat_sel), .stat_lock(stat_lock)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_idx(input bit top, input int a);
      int hi = a >> 15;
      int lo = (a >> 12) & 7;
      if (top) return (hi == 31) ? 31 + lo : hi;
      return (hi == 0) ? lo : 7 + hi;
   endfunction

   task automatic send(input logic [1:0] op, input int a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = 20'(a);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic rd(input int idx, output logic [1:0] v);
      stat_sel = 6'(idx);
      #1 v = stat_lock;
   endtask

   task automatic probe(input int a, output logic p);
      req_addr = 20'(a); req_valid = 1'b1;
      #1 p = req_permit;
      req_valid = 1'b0;
   endtask

   task automatic t_reset();
      logic [1:0] v;
      logic p;
      for (int i = 0; i < 39; i++) begin
         rd(i, v);
         chk(v == 2'b01, "R1 reset status", v, 1);
      end
      probe(20'h12345, p);
      chk(p == 1'b0, "R1 reset deny", p, 0);
   endtask

   task automatic t_decode(input bit top, input int a);
      logic [1:0] v;
      logic p;
      int e = exp_idx(top, a);
      small_at_top = top;
      send(2'b10, a);
      rd(e, v);
      chk(v == 2'b00, top ? "R3 R5 unlock at decoded sector" : "R2 R5 unlock at decoded sector", v, 0);
      probe(a, p);
      chk(p == 1'b1, "R8 permit open sector", p, 1);
      send(2'b01, a);
      rd(e, v);
      chk(v == 2'b01, "R4 relock", v, 1);
      probe(a, p);
      chk(p == 1'b0, "R8 deny locked sector", p, 0);
   endtask

   task automatic t_freeze();
      logic [1:0] v;
      logic p;
      small_at_top = 1'b0;
      send(2'b10, 20'h05000);
      send(2'b11, 20'h05000);
      rd(5, v);
      chk(v == 2'b11, "R6 R11 freeze from open", v, 3);
      send(2'b01, 20'h05000);
      rd(5, v);
      chk(v == 2'b11, "R6 lock keeps frozen", v, 3);
      wp_hold = 1'b1;
      send(2'b10, 20'h05000);
      rd(5, v);
      chk(v == 2'b11, "R7 unlock ignored under hold", v, 3);
      probe(20'h05000, p);
      chk(p == 1'b0, "R8 frozen denies", p, 0);
      wp_hold = 1'b0;
      send(2'b10, 20'h05000);
      rd(5, v);
      chk(v == 2'b00, "R7 unlock after hold release", v, 0);
      wp_hold = 1'b1;
      send(2'b11, 20'h60000);
      rd(19, v);
      chk(v == 2'b11, "R6 freeze from locked", v, 3);
   endtask

   task automatic t_vpp();
      logic p;
      small_at_top = 1'b0;
      send(2'b10, 20'h68000);
      vpp_low = 1'b1;
      probe(20'h68000, p);
      chk(p == 1'b0, "R9 vpp low denies open sector", p, 0);
      vpp_low = 1'b0;
      probe(20'h68000, p);
      chk(p == 1'b1, "R9 vpp ok permits", p, 1);
   endtask

   task automatic t_err();
      logic [1:0] v;
      small_at_top = 1'b0;
      @(negedge clk);
      req_addr = 20'hA0000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(err_valid == 1'b1, "R10 error pulse", err_valid, 1);
      chk(err_sector == 6'd27, "R10 error sector", err_sector, 27);
      @(negedge clk); #1;
      chk(err_valid == 1'b0, "R10 pulse one cycle", err_valid, 0);
      @(negedge clk);
      req_addr = 20'h68000; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(err_valid == 1'b0, "R10 no error when permitted", err_valid, 0);
      rd(45, v);
      chk(v == 2'b00, "R11 out of range select", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_decode(1'b0, 20'h00000);
      t_decode(1'b0, 20'h07FFF);
      t_decode(1'b0, 20'h08000);
      t_decode(1'b0, 20'h3C123);
      t_decode(1'b0, 20'hFFFFF);
      t_decode(1'b1, 20'h00000);
      t_decode(1'b1, 20'hF7FFF);
      t_decode(1'b1, 20'hF8000);
      t_decode(1'b1, 20'hF9ABC);
      t_decode(1'b1, 20'hFFFFF);
      t_freeze();
      t_vpp();
      t_err();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule